// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Match Scheduler

This block computes, once per cell timeslot, which input port of an N-port input-queued crossbar is connected to which output port. Every input keeps one logical queue per output, and the flags showing which of those queues hold a cell form an N-by-N request matrix. On a timeslot strobe the scheduler takes a snapshot of that matrix. It then runs a fixed number of matching iterations, one per clock. In each iteration every free output grants one requesting free input, and every free input accepts one of the grants it received. Both choices are round-robin and start from a pointer kept per output (grant side) and per input (accept side).

Pairs formed in an iteration are kept in all later iterations. After the last iteration the one-to-one match is loaded into an output register and announced with a one-cycle valid pulse. The crossbar forwarding logic then moves one cell for every matched input. The match pins are a plain strobe-qualified result with no back-pressure. The consumer must take the result in the pulse cycle, and the register keeps that result until the next pulse. The timeslot strobe is also a plain control pin. It is acted on only while the scheduler is idle.

Top module: `rgx_sched`

## Requirements
- R1: Bit `i*N+o` of `req_mat` means input i has a cell for output o. The matrix is sampled only on the clock edge that accepts `slot_start`. Changes to `req_mat` after that edge do not affect the result.
- R2: `match_valid` is high for exactly one cycle. It rises on the ITERS-th rising edge after the edge that accepted `slot_start`.
- R3: A `slot_start` seen while an iteration sequence is running is ignored. The running result is unchanged, and no extra `match_valid` pulse follows. `slot_start` is accepted again from the cycle in which `match_valid` is high.
- R4: In a result, every matched input was requesting its matched output in the snapshot, and no output is given to two inputs.
- R5: A free output grants the first requesting free input at or after its grant pointer, counting upward with wrap from N-1 to 0. A free input accepts the first granting output at or after its accept pointer, in the same order.
- R6: All pointers reset to 0. A pointer moves to one past the port it chose (wrapping N to 0), and only when that choice ends in an acceptance during the first iteration of a timeslot.
- R7: Iterations after the first consider only inputs and outputs still unmatched, and never remove an existing pair.
- R8: When ITERS equals N, the result is maximal: no requested pair has both its input and its output unmatched.
- R9: After reset, `match_valid` is 0, no input is matched and all ports read 0. Between pulses `match_hit` and `match_port` hold their value. An unmatched input reports port 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | input | 1 | Timeslot strobe; starts a schedule when idle |
| req_mat | input | N*N | Queue-occupied matrix, bit i*N+o = input i to output o |
| match_valid | output | 1 | One-cycle pulse when a new match is loaded |
| match_hit | output | N | Bit i set when input i is matched |
| match_port | output | N*IW | Output index for input i in bits i*IW +: IW, IW = clog2(N) |

## Verification
The bench builds the scheduler with N = 4 and ITERS = 4. With these values the iteration count equals the port count, so every schedule must reach a maximal match. This brings the maximality property and the full chain of later-iteration fills within reach. It also exercises the rule that later iterations leave the pointers alone, because only first-iteration acceptances move them. Hand-worked schedules on a full request matrix check the pointer rotation exactly. Random matrices and strobes that arrive while the scheduler is busy are compared against a behavioural model on every clock.

// File: rtl/rgx_pkg.sv
package rgx_pkg;

  // Successor of a port index with wrap at n.
  function automatic int unsigned rgx_succ(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/rgx_rr_pick.sv
module rgx_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  pick
);

  logic          found;
  logic [IW-1:0] idx;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      idx = IW'((int'(ptr) + k) % N);
      if (!found && req[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rgx_grant_stage.sv
module rgx_grant_stage #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N*N-1:0]  elig,
  input  logic [N*IW-1:0] gptr,
  output logic [N*N-1:0]  gnt
);

  for (genvar o = 0; o < N; o++) begin : g_out
    logic [N-1:0] col;
    logic [N-1:0] pk;
    for (genvar i = 0; i < N; i++) begin : g_in
      assign col[i]       = elig[i*N+o];
      assign gnt[i*N+o]   = pk[i];
    end
    rgx_rr_pick #(.N(N), .IW(IW)) u_pick (
      .req  (col),
      .ptr  (gptr[o*IW +: IW]),
      .pick (pk)
    );
  end

endmodule

// File: rtl/rgx_accept_stage.sv
module rgx_accept_stage #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N*N-1:0]  gnt,
  input  logic [N*IW-1:0] aptr,
  output logic [N*N-1:0]  acc
);

  for (genvar i = 0; i < N; i++) begin : g_in
    rgx_rr_pick #(.N(N), .IW(IW)) u_pick (
      .req  (gnt[i*N +: N]),
      .ptr  (aptr[i*IW +: IW]),
      .pick (acc[i*N +: N])
    );
  end

endmodule

// File: rtl/rgx_sched.sv
module rgx_sched #(
  parameter int N     = 4,
  parameter int ITERS = 2,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int CW   = $clog2(ITERS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_start,
  input  logic [N*N-1:0]  req_mat,
  output logic            match_valid,
  output logic [N-1:0]    match_hit,
  output logic [N*IW-1:0] match_port
);
  import rgx_pkg::*;

  logic            busy;
  logic [CW-1:0]   iter_q;
  logic [N*N-1:0]  req_q;
  logic [N-1:0]    in_m;
  logic [N-1:0]    out_m;
  logic [N*IW-1:0] wport;
  logic [N*IW-1:0] gptr_q;
  logic [N*IW-1:0] aptr_q;

  logic [N*N-1:0]  elig;
  logic [N*N-1:0]  gnt;
  logic [N*N-1:0]  acc;
  logic [N-1:0]    acc_in;
  logic [N-1:0]    acc_out;
  logic [IW-1:0]   acc_port [N];
  logic [IW-1:0]   acc_src  [N];
  logic            first_it;
  logic            last_it;

  // Only free inputs and free outputs take part in an iteration.
  for (genvar i = 0; i < N; i++) begin : g_ei
    for (genvar o = 0; o < N; o++) begin : g_eo
      assign elig[i*N+o] = req_q[i*N+o] & ~in_m[i] & ~out_m[o];
    end
  end

  rgx_grant_stage #(.N(N), .IW(IW)) u_grant (
    .elig (elig),
    .gptr (gptr_q),
    .gnt  (gnt)
  );

  rgx_accept_stage #(.N(N), .IW(IW)) u_accept (
    .gnt  (gnt),
    .aptr (aptr_q),
    .acc  (acc)
  );

  // Encode the acceptance matrix per input row and per output column.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      acc_in[i]   = |acc[i*N +: N];
      acc_port[i] = '0;
      for (int o = 0; o < N; o++) begin
        if (acc[i*N+o]) acc_port[i] = IW'(o);
      end
    end
    for (int o = 0; o < N; o++) begin
      acc_out[o] = 1'b0;
      acc_src[o] = '0;
      for (int i = 0; i < N; i++) begin
        if (acc[i*N+o]) begin
          acc_out[o] = 1'b1;
          acc_src[o] = IW'(i);
        end
      end
    end
  end

  assign first_it = (iter_q == '0);
  assign last_it  = (iter_q == CW'(ITERS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      iter_q      <= '0;
      req_q       <= '0;
      in_m        <= '0;
      out_m       <= '0;
      wport       <= '0;
      gptr_q      <= '0;
      aptr_q      <= '0;
      match_valid <= 1'b0;
      match_hit   <= '0;
      match_port  <= '0;
    end else begin
      match_valid <= 1'b0;
      if (!busy) begin
        if (slot_start) begin
          busy   <= 1'b1;
          iter_q <= '0;
          req_q  <= req_mat;
          in_m   <= '0;
          out_m  <= '0;
          wport  <= '0;
        end
      end else begin
        in_m   <= in_m | acc_in;
        out_m  <= out_m | acc_out;
        iter_q <= iter_q + 1'b1;
        for (int i = 0; i < N; i++) begin
          if (acc_in[i]) wport[i*IW +: IW] <= acc_port[i];
        end
        if (first_it) begin
          for (int o = 0; o < N; o++) begin
            if (acc_out[o])
              gptr_q[o*IW +: IW] <= IW'(rgx_succ(int'(acc_src[o]), N));
          end
          for (int i = 0; i < N; i++) begin
            if (acc_in[i])
              aptr_q[i*IW +: IW] <= IW'(rgx_succ(int'(acc_port[i]), N));
          end
        end
        if (last_it) begin
          busy        <= 1'b0;
          match_valid <= 1'b1;
          match_hit   <= in_m | acc_in;
          for (int i = 0; i < N; i++) begin
            match_port[i*IW +: IW] <= acc_in[i] ? acc_port[i] : wport[i*IW +: IW];
          end
        end
      end
    end
  end

endmodule

// File: rtl/rgx_sched_chk.sv
module rgx_sched_chk #(
  parameter int N     = 4,
  parameter int ITERS = 2,
  parameter int IW    = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            slot_start,
  input logic [N*N-1:0]  req_mat,
  input logic            match_valid,
  input logic [N-1:0]    match_hit,
  input logic [N*IW-1:0] match_port
);

  int unsigned    cnt;
  logic           fire;
  logic [N*N-1:0] snap;
  logic           dup;
  logic           unreq;
  logic           nonmax;
  logic           stray;
  logic [N-1:0]   used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= 0;
      fire <= 1'b0;
      snap <= '0;
    end else begin
      fire <= (cnt == 1);
      if (cnt == 0 && slot_start) begin
        cnt  <= ITERS;
        snap <= req_mat;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
      end
    end
  end

  always_comb begin
    dup    = 1'b0;
    unreq  = 1'b0;
    nonmax = 1'b0;
    stray  = 1'b0;
    used   = '0;
    for (int i = 0; i < N; i++) begin
      if (match_hit[i]) begin
        if (used[match_port[i*IW +: IW]]) dup = 1'b1;
        used[match_port[i*IW +: IW]] = 1'b1;
        if (!snap[i*N + int'(match_port[i*IW +: IW])]) unreq = 1'b1;
      end else if (match_port[i*IW +: IW] != '0) begin
        stray = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      for (int o = 0; o < N; o++) begin
        if (snap[i*N+o] && !match_hit[i] && !used[o]) nonmax = 1'b1;
      end
    end
  end

  AST_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid == fire); // R2

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |=> !match_valid); // R3

  AST_ONE_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> !dup); // R4

  AST_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> !unreq); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> ($stable(match_hit) && $stable(match_port))); // R9

  AST_FREE_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !stray); // R9

  if (ITERS == N) begin : g_max
    AST_MAXIMAL: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> !nonmax); // R8
  end

endmodule

bind rgx_sched rgx_sched_chk #(.N(N), .ITERS(ITERS), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_start  (slot_start),
  .req_mat     (req_mat),
  .match_valid (match_valid),
  .match_hit   (match_hit),
  .match_port  (match_port)
);

// File: tb/tb_rgx_sched.sv
module tb_rgx_sched;
  localparam int N     = 4;
  localparam int ITERS = 4;
  localparam int IW    = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            slot_start;
  logic [N*N-1:0]  req_mat;
  logic            match_valid;
  logic [N-1:0]    match_hit;
  logic [N*IW-1:0] match_port;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  rgx_sched #(.N(N), .ITERS(ITERS)) dut (
    .clk (clk), .rst_n (rst_n), .slot_start (slot_start), .req_mat (req_mat),
    .match_valid (match_valid), .match_hit (match_hit), .match_port (match_port)
  );

  // Behavioural reference model, updated on each rising edge.
  bit m_busy, m_valid;
  int m_it;
  bit snap [N][N];
  bit inm [N];
  bit outm [N];
  int wp [N];
  int gp [N];
  int ap [N];
  int g  [N];
  bit m_hit [N];
  int m_port [N];
  int a;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_it = 0;
      for (int i = 0; i < N; i++) begin
        gp[i] = 0; ap[i] = 0; m_hit[i] = 0; m_port[i] = 0;
        inm[i] = 0; outm[i] = 0; wp[i] = 0;
      end
    end else begin
      m_valid = 0;
      if (!m_busy) begin
        if (slot_start) begin
          m_busy = 1; m_it = 0;
          for (int i = 0; i < N; i++) begin
            inm[i] = 0; outm[i] = 0; wp[i] = 0;
            for (int o = 0; o < N; o++) snap[i][o] = req_mat[i*N+o];
          end
        end
      end else begin
        for (int o = 0; o < N; o++) begin
          g[o] = -1;
          if (!outm[o])
            for (int k = 0; k < N; k++) begin
              int i;
              i = (gp[o] + k) % N;
              if (g[o] < 0 && snap[i][o] && !inm[i]) g[o] = i;
            end
        end
        for (int i = 0; i < N; i++) begin
          if (!inm[i]) begin
            a = -1;
            for (int k = 0; k < N; k++) begin
              int o;
              o = (ap[i] + k) % N;
              if (a < 0 && g[o] == i) a = o;
            end
            if (a >= 0) begin
              inm[i] = 1; outm[a] = 1; wp[i] = a;
              if (m_it == 0) begin
                ap[i] = (a + 1) % N;
                gp[a] = (i + 1) % N;
              end
            end
          end
        end
        m_it++;
        if (m_it == ITERS) begin
          m_busy = 0; m_valid = 1;
          for (int i = 0; i < N; i++) begin
            m_hit[i] = inm[i]; m_port[i] = wp[i];
          end
        end
      end
    end
  end

  function automatic int port_of(int i);
    return int'(match_port[i*IW +: IW]);
  endfunction

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (match_valid !== m_valid) begin
        fails++;
        $display("FAIL R2 match_valid act=%0b exp=%0b t=%0t", match_valid, m_valid, $time);
      end
      for (int i = 0; i < N; i++) begin
        if (match_hit[i] !== m_hit[i] || port_of(i) != m_port[i]) begin
          fails++;
          $display("FAIL R5 input %0d act=%0b/%0d exp=%0b/%0d t=%0t",
                   i, match_hit[i], port_of(i), m_hit[i], m_port[i], $time);
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Drive one schedule; returns at the negedge where match_valid is expected high.
  task automatic run_slot(input logic [N*N-1:0] r);
    @(negedge clk); slot_start = 1'b1; req_mat = r;
    @(negedge clk); slot_start = 1'b0; req_mat = ~r;   // R1: late change ignored
    repeat (ITERS - 1) @(negedge clk);
    check("R2 valid low one cycle early", match_valid, 0);
    @(negedge clk);
    check("R2 valid on ITERS-th edge", match_valid, 1);
  endtask

  task automatic check_struct(input logic [N*N-1:0] r);
    bit used [N];
    for (int o = 0; o < N; o++) used[o] = 0;
    for (int i = 0; i < N; i++)
      if (match_hit[i]) begin
        check("R4 no shared output", used[port_of(i)], 0);
        check("R4 pair was requested", r[i*N + port_of(i)], 1);
        used[port_of(i)] = 1;
      end
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++)
        if (r[i*N+o] && !match_hit[i]) check("R8 maximal", used[o], 1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; slot_start = 1'b0; req_mat = '0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", match_valid, 0);
    check("R9 reset hit", match_hit, 0);
    check("R9 reset port", match_port, 0);
    rst_n = 1'b1;

    // Full matrix from reset pointers: fills the diagonal, one pair per iteration.
    run_slot('1);
    check("R7 first slot hit", match_hit, 4'hF);
    for (int i = 0; i < N; i++) check("R7 first slot identity", port_of(i), i);

    // Only first-iteration pointers moved (out0 -> 1, in0 -> 1).
    run_slot('1);
    check("R6 in0 port", port_of(0), 1);
    check("R6 in1 port", port_of(1), 0);
    check("R5 in2 port", port_of(2), 2);
    check("R5 in3 port", port_of(3), 3);
    @(negedge clk);
    check("R9 hold after pulse", port_of(0), 1);

    // Empty matrix: nothing matched, ports at 0.
    run_slot('0);
    check("R9 empty hit", match_hit, 0);
    check("R9 empty port", match_port, 0);

    // Single request, with a busy-time strobe carrying a full matrix.
    @(negedge clk); slot_start = 1'b1; req_mat = 16'h0800;
    @(negedge clk); slot_start = 1'b1; req_mat = '1;  // R3: ignored while busy
    @(negedge clk); slot_start = 1'b0; req_mat = '1;
    repeat (ITERS - 2) @(negedge clk);
    check("R3 no early pulse", match_valid, 0);
    @(negedge clk);
    check("R3 single pulse", match_valid, 1);
    check("R1 single hit", match_hit, 4'b0100);
    check("R1 single port", port_of(2), 3);
    @(negedge clk); req_mat = '0;
    check("R3 no second pulse", match_valid, 0);

    // Random matrices with structural checks.
    for (int n = 0; n < 150; n++) begin
      logic [N*N-1:0] r;
      r = N*N'($urandom);
      run_slot(r);
      check_struct(r);
    end

    // Free-running stress: random strobes, including during busy and pulse cycles.
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      slot_start = ($urandom % 3) == 0;
      req_mat    = N*N'($urandom);
    end
    @(negedge clk); slot_start = 1'b0;
    repeat (ITERS + 2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule